// File: doc/BRIEF.md
# Down-Counting PWM Timer Channel

This block is one channel of a pulse-width timer. Software-facing logic writes a period value and a duty value into two buffer registers. A down-counter and an active compare register run the waveform. They take new values only when a manual-update strobe is given, or when the counter expires with auto-reload enabled. A tick-enable input, driven by an upstream clock-select stage, sets the rate at which the counter steps.

The output is in its active phase while the counter value is at or below the active compare value. This gives a duty of compare+1 ticks in a period of count+1 ticks. A compare value at or above the count gives a constant active level. A configurable inverter sets the output sense. To stop the channel, auto-reload is cleared: the running period finishes, one expiry pulse is raised, and the channel halts until the next manual update.

Top module: `pwm_tmr_chan`

## Requirements
- R1: While `manualUpd` is high, the active counter and active compare register load from the buffers on each clock edge. While the channel runs, each edge with `tickEn` high and a nonzero counter decrements `cntValue` by one.
- R2: With `autoReload` high, a period lasts N+1 ticks for a count buffer value N. On the tick where the counter is 0, it reloads both active registers from the buffers, and `expirePulse` is high for the following cycle only.
- R3: The active phase holds while the running counter is less than or equal to the active compare value. A compare of 0 gives one active tick per period. A compare of 16'hFFFF, or any value not below the count, gives the active phase on every tick.
- R4: Writing `cntWrData` or `cmpWrData` while the channel runs does not change the counter sequence or the output of the current period. The new values take effect at the next reload.
- R5: If `autoReload` is low when the counter expires, the channel raises one expiry pulse and halts with the counter at 0 and the output idle. It raises no further expiry pulses until the next manual update.
- R6: With `invertCtl` high, `pwmOut` is 1 during the active phase and 0 when idle. With `invertCtl` low, both levels are inverted.
- R7: On cycles where `tickEn` is low, the counter holds its value and no expiry occurs.
- R8: After reset, the counter and both buffers are 0, the channel is stopped, `expirePulse` is 0, and `pwmOut` is at the idle level for the current `invertCtl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Counter step enable from clock-select stage |
| cntWrEn | input | 1 | Count buffer write strobe |
| cntWrData | input | CNT_W | Count buffer data (period ticks minus one) |
| cmpWrEn | input | 1 | Compare buffer write strobe |
| cmpWrData | input | CNT_W | Compare buffer data (duty ticks minus one) |
| startCtl | input | 1 | Run enable |
| manualUpd | input | 1 | Copy buffers into active registers |
| invertCtl | input | 1 | Output inverter control |
| autoReload | input | 1 | Reload at expiry when high, halt when low |
| pwmOut | output | 1 | PWM output after the inverter |
| expirePulse | output | 1 | One-cycle pulse after each expiry |
| cntValue | output | CNT_W | Current down-counter value |

## Verification
The main waveform is run with short periods and compare values of 0, in the middle, and all ones. This separates an off-by-one in the period or duty from a wrong compare direction, and it exposes a missing 100% case. The same period is run with both inverter settings, which shows whether the idle and active levels are swapped. Further sequences cover the following: buffer writes in the middle of a period, which catch early loading; clearing auto-reload in the middle of a period, which checks that the period completes and that the channel halts; and gaps in the tick enable, which show whether the counter ignores its step enable.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic loadAct; // copy buffers into active registers
    logic dec;     // step the down-counter
    logic run;     // channel is running (not stopped, not halted)
  } tmrStrobeT;
endpackage

// File: rtl/pwm_tmr_ctrl.sv
module pwm_tmr_ctrl
  import pwm_tmr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tickEn,
  input  logic      startCtl,
  input  logic      manualUpd,
  input  logic      autoReload,
  input  logic      cntZero,
  output tmrStrobeT strb,
  output logic      expirePulse
);
  logic halted;
  logic running;
  logic expireNow;

  assign running   = startCtl && !halted;
  assign expireNow = !manualUpd && tickEn && running && cntZero;

  always_comb begin
    strb.run     = running;
    strb.loadAct = manualUpd || (expireNow && autoReload);
    strb.dec     = !manualUpd && tickEn && running && !cntZero;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted      <= 1'b0;
      expirePulse <= 1'b0;
    end else begin
      expirePulse <= expireNow;
      if (manualUpd)
        halted <= 1'b0;
      else if (expireNow && !autoReload)
        halted <= 1'b1;
    end
  end
endmodule

// File: rtl/pwm_tmr_datapath.sv
module pwm_tmr_datapath
  import pwm_tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmrStrobeT        strb,
  input  logic             cntWrEn,
  input  logic [CNT_W-1:0] cntWrData,
  input  logic             cmpWrEn,
  input  logic [CNT_W-1:0] cmpWrData,
  input  logic             invertCtl,
  output logic             cntZero,
  output logic             pwmOut,
  output logic [CNT_W-1:0] cntValue
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cntBuf, cmpBuf;
  logic [CNT_W-1:0] cntAct, cmpAct;
  logic             activePhase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cntBuf <= '0;
      cmpBuf <= '0;
    end else begin
      if (cntWrEn) cntBuf <= cntWrData;
      if (cmpWrEn) cmpBuf <= cmpWrData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cntAct <= '0;
      cmpAct <= '0;
    end else if (strb.loadAct) begin
      cntAct <= cntBuf;
      cmpAct <= cmpBuf;
    end else if (strb.dec) begin
      cntAct <= cntAct - ONE;
    end
  end

  assign cntZero     = (cntAct == '0);
  assign activePhase = strb.run && (cntAct <= cmpAct);
  assign pwmOut      = invertCtl ? activePhase : !activePhase;
  assign cntValue    = cntAct;
endmodule

// File: rtl/pwm_tmr_chan.sv
module pwm_tmr_chan
  import pwm_tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tickEn,
  input  logic             cntWrEn,
  input  logic [CNT_W-1:0] cntWrData,
  input  logic             cmpWrEn,
  input  logic [CNT_W-1:0] cmpWrData,
  input  logic             startCtl,
  input  logic             manualUpd,
  input  logic             invertCtl,
  input  logic             autoReload,
  output logic             pwmOut,
  output logic             expirePulse,
  output logic [CNT_W-1:0] cntValue
);
  tmrStrobeT strb;
  logic      cntZero;

  pwm_tmr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .startCtl(startCtl),
    .manualUpd(manualUpd), .autoReload(autoReload), .cntZero(cntZero),
    .strb(strb), .expirePulse(expirePulse)
  );

  pwm_tmr_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .cntWrEn(cntWrEn), .cntWrData(cntWrData),
    .cmpWrEn(cmpWrEn), .cmpWrData(cmpWrData),
    .invertCtl(invertCtl), .cntZero(cntZero),
    .pwmOut(pwmOut), .cntValue(cntValue)
  );
endmodule

// File: rtl/pwm_tmr_chan_chk.sv
module pwm_tmr_chan_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tickEn,
  input logic             startCtl,
  input logic             manualUpd,
  input logic             autoReload,
  input logic             expirePulse,
  input logic [CNT_W-1:0] cntValue
);
  p_decrement_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tickEn && startCtl && !manualUpd && cntValue != '0)
      |=> cntValue == CNT_W'($past(cntValue) - CNT_W'(1)));

  p_expire_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    expirePulse |-> ($past(tickEn) && $past(cntValue) == '0 && !$past(manualUpd)));

  p_halt_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (expirePulse && !$past(autoReload)) |-> cntValue == '0);

  p_halt_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (expirePulse && !$past(autoReload)) |=> !expirePulse);

  p_hold_no_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tickEn && !manualUpd) |=> ($stable(cntValue) && !expirePulse));
endmodule

bind pwm_tmr_chan pwm_tmr_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .startCtl(startCtl),
  .manualUpd(manualUpd), .autoReload(autoReload),
  .expirePulse(expirePulse), .cntValue(cntValue)
);

// File: tb/pwm_tmr_chan_bench.sv
module pwm_tmr_chan_bench;
  localparam int CLK_P = 10;
  localparam int W = 16;
  localparam int NONE = 99;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tickEn = 1'b0, cntWrEn = 1'b0, cmpWrEn = 1'b0;
  logic [W-1:0] cntWrData = '0, cmpWrData = '0;
  logic startCtl = 1'b0, manualUpd = 1'b0, invertCtl = 1'b0, autoReload = 1'b0;
  logic pwmOut, expirePulse;
  logic [W-1:0] cntValue;

  int nCmp = 0, nBad = 0;

  typedef struct {
    logic [W-1:0] c;
    logic         ex;
    logic         out;
    string        tag;
  } expItemT;
  expItemT expQ[$];

  always #(CLK_P/2) clk = ~clk;

  pwm_tmr_chan #(.CNT_W(W)) u_pwm_tmr_chan (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn),
    .cntWrEn(cntWrEn), .cntWrData(cntWrData),
    .cmpWrEn(cmpWrEn), .cmpWrData(cmpWrData),
    .startCtl(startCtl), .manualUpd(manualUpd), .invertCtl(invertCtl),
    .autoReload(autoReload), .pwmOut(pwmOut), .expirePulse(expirePulse),
    .cntValue(cntValue)
  );

  task automatic check(string tag, logic [W-1:0] c, logic ex, logic out);
    nCmp++;
    if (cntValue !== c || expirePulse !== ex || pwmOut !== out) begin
      nBad++;
      $display("FAIL %s: got cnt=%0d exp=%b out=%b, expected cnt=%0d exp=%b out=%b",
               tag, cntValue, expirePulse, pwmOut, c, ex, out);
    end
  endtask

  // Monitor: pops one expected item per falling edge
  always @(negedge clk) begin
    if (expQ.size() != 0) begin
      expItemT it;
      it = expQ.pop_front();
      check(it.tag, it.c, it.ex, it.out);
    end
  end

  // Driver: sets up a run and pushes the expected sample sequence
  task automatic runSeq(string tag, int n, int d, int n2, int d2, int wrAt,
                        int stopAt, logic inv, int nSamp, logic [63:0] tick);
    logic [W-1:0] bufN, bufD, c, dAct;
    logic ex, halt, auto, act;
    @(posedge clk); #1;
    cntWrEn = 1; cntWrData = W'(n); cmpWrEn = 1; cmpWrData = W'(d);
    invertCtl = inv; startCtl = 0; autoReload = 0; manualUpd = 0;
    @(posedge clk); #1;
    cntWrEn = 0; cmpWrEn = 0; manualUpd = 1;
    @(posedge clk); #1;
    manualUpd = 0; startCtl = 1; autoReload = 1;
    // expected sequence from the requirements
    bufN = W'(n); bufD = W'(d); c = W'(n); dAct = W'(d);
    ex = 0; halt = 0; auto = 1;
    for (int j = 0; j < nSamp; j++) begin
      expItemT it;
      act = !halt && (c <= dAct);
      it.c = c; it.ex = ex; it.out = inv ? act : !act; it.tag = tag;
      expQ.push_back(it);
      if (j == wrAt) begin bufN = W'(n2); bufD = W'(d2); end
      if (j == stopAt) auto = 0;
      ex = 0;
      if (tick[j] && !halt) begin
        if (c == '0) begin
          ex = 1;
          if (auto) begin c = bufN; dAct = bufD; end
          else halt = 1;
        end else c = c - W'(1);
      end
    end
    for (int j = 0; j < nSamp; j++) begin
      if (j != 0) begin @(posedge clk); #1; end
      cntWrEn = 0; cmpWrEn = 0;
      tickEn = tick[j];
      if (j == wrAt) begin cntWrEn = 1; cntWrData = W'(n2); cmpWrEn = 1; cmpWrData = W'(d2); end
      if (j == stopAt) autoReload = 0;
    end
    @(posedge clk); #1;
    cntWrEn = 0; cmpWrEn = 0; tickEn = 0;
    while (expQ.size() != 0) @(negedge clk);
    #1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R8: reset state, invert low gives idle high
    @(negedge clk);
    check("R8 reset", '0, 1'b0, 1'b1);
    rst_n = 1;
    @(posedge clk); #1;
    @(negedge clk);
    check("R8 after release", '0, 1'b0, 1'b1);

    // R1/R2: period 5, duty 2, invert high
    runSeq("R2 period", 4, 1, 0, 0, NONE, NONE, 1'b1, 12, '1);
    // R3: compare all ones -> always active
    runSeq("R3 full", 3, 16'hFFFF, 0, 0, NONE, NONE, 1'b1, 9, '1);
    // R3: compare 0 -> one active tick per period
    runSeq("R3 min", 3, 0, 0, 0, NONE, NONE, 1'b1, 9, '1);
    // R6: invert low complements the waveform
    runSeq("R6 invert", 4, 1, 0, 0, NONE, NONE, 1'b0, 11, '1);
    // R4: buffer writes mid-period wait for reload
    runSeq("R4 buffered", 5, 2, 2, 0, 2, NONE, 1'b1, 13, '1);
    // R5: clear auto-reload mid-period, finish and halt
    runSeq("R5 stop", 3, 1, 0, 0, NONE, 1, 1'b1, 10, '1);
    // R7: gaps in tick enable hold the counter
    runSeq("R7 tick", 3, 1, 0, 0, NONE, NONE, 1'b1, 14, 64'hFFFF_FFFF_FFFF_D3A5);
    // R1: manual update reloads after a halt
    runSeq("R1 reload", 2, 0, 0, 0, NONE, NONE, 1'b1, 7, '1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule